// File: doc/BRIEF.md
# Uplink Long Scrambling Code Generator

This block produces the complex uplink long scrambling sequence, one chip per enabled clock, for a 24-bit code index. Two 25-stage binary shift registers run side by side. The sum of their outputs gives a real Gold-type sequence, c1. A second sum of the same two registers, taken far ahead in phase, gives c2. The I chip is c1. The Q chip is c1 multiplied by a copy of c2 that is decimated by two and given an alternating sign.

A load strobe captures the index and starts a frame at chip 0. The block then steps once for each cycle in which chip-enable is high. After 38400 chips both registers return to their seed values, and the same frame repeats with the stored index. Each chip is output as a sign bit: 0 stands for +1 and 1 stands for −1.

Top module: `ul_long_scrambler`

## Requirements
- R1: During reset and after reset, until the first load, chip_i_o, chip_q_o, frame_start_o and index_o are all 0, and a high chip_en_i changes none of them.
- R2: One cycle after the clock edge that samples load_i high, the outputs present chip 0 of a frame: frame_start_o is 1 and index_o equals the index_i value sampled on that edge.
- R3: At chip 0, stage k of the x register (k = 0..23) holds index bit k, and stage 24 holds 1. Every stage of the y register holds 1. x follows s(n+25) = s(n+3) ⊕ s(n), and y follows s(n+25) = s(n+3) ⊕ s(n+2) ⊕ s(n+1) ⊕ s(n). chip_i_o at chip i is c1(i) = x(i) ⊕ y(i). For example, index 1 gives chip_i_o = 0 at chip 0, and index 0 gives chip_i_o = 1.
- R4: c2(i) = x(i+16777232) ⊕ y(i+16777232). It is formed from the current register state through fixed tap masks, without stepping through the offset.
- R5: chip_q_o at chip i is c1(i) ⊕ (i mod 2) ⊕ c2(2·floor(i/2)). On an odd chip, this means the c2 value of the chip just before it.
- R6: When chip_en_i is low and load_i is low, no output changes on that clock edge.
- R7: After chip 38399 of a frame, the next enabled edge returns to chip 0 with the stored index. frame_start_o is then 1 again, and index_o is unchanged.
- R8: A load in the middle of a frame abandons that frame at once. The next cycle is chip 0 of the new index.
- R9: A load takes effect whatever the value of chip_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture index_i and restart at chip 0 |
| index_i | input | 24 | Scrambling code index |
| chip_en_i | input | 1 | Advance one chip on this edge |
| chip_i_o | output | 1 | I chip sign bit (0 = +1, 1 = −1) |
| chip_q_o | output | 1 | Q chip sign bit (0 = +1, 1 = −1) |
| frame_start_o | output | 1 | High while chip 0 is presented |
| index_o | output | 24 | Index of the frame being produced |

## Verification
A behavioural model in the bench steps two pairs of registers. The second pair is advanced 16777232 steps at load time, so a wrong tap mask shows up as a Q chip that disagrees with the model. Pairing is checked under an irregular enable pattern. A design that took c2 from the odd chip, or that failed to freeze the held value during a stall, would flip Q on alternate chips. A full frame is run to check that the wrap happens exactly after chip 38399; a frame one chip off would move the second frame_start_o. Loads in the middle of a frame and loads with chip_en_i low are both exercised. A design that waited for the frame end, or that gated the load with the enable, would keep producing the old sequence.

// File: rtl/ul_scr_pkg.sv
package ul_scr_pkg;

   localparam int unsigned LFSR_W = 25;

   typedef logic [LFSR_W-1:0] lfsr_state_t;

   // recurrence taps (term x^25 implied)
   localparam lfsr_state_t X_TAPS_DEF = lfsr_state_t'(25'h0000009);
   localparam lfsr_state_t Y_TAPS_DEF = lfsr_state_t'(25'h000000F);

   // a*b modulo (x^LFSR_W + taps)
   function automatic lfsr_state_t poly_mulmod(lfsr_state_t a, lfsr_state_t b,
                                               lfsr_state_t taps);
      logic [LFSR_W:0] r;
      r = '0;
      for (int i = LFSR_W - 1; i >= 0; i--) begin
         r = r << 1;
         if (r[LFSR_W]) r = r ^ {1'b1, taps};
         if (b[i]) r = r ^ {1'b0, a};
      end
      return r[LFSR_W-1:0];
   endfunction

   // x^k modulo the generator: tap mask that looks k steps ahead
   function automatic lfsr_state_t poly_powmod(int unsigned k, lfsr_state_t taps);
      lfsr_state_t acc;
      lfsr_state_t base;
      acc  = lfsr_state_t'(1);
      base = lfsr_state_t'(2);
      for (int b = 0; b < 32; b++) begin
         if (((k >> b) & 32'd1) != 32'd0) acc = poly_mulmod(acc, base, taps);
         base = poly_mulmod(base, base, taps);
      end
      return acc;
   endfunction

endpackage

// File: rtl/ul_scr_lfsr.sv
module ul_scr_lfsr
   import ul_scr_pkg::*;
#(
   parameter lfsr_state_t TAPS   = X_TAPS_DEF,
   parameter int unsigned OFFSET = 16777232
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load_i,
   input  logic        step_i,
   input  lfsr_state_t seed_i,
   output logic        seq_now_o,
   output logic        seq_ahead_o
);

   localparam lfsr_state_t AHEAD_MASK = poly_powmod(OFFSET, TAPS);

   generate
      if (!TAPS[0]) begin : g_bad_taps
         $error("ul_scr_lfsr: tap set lacks the constant term");
      end
   endgenerate

   lfsr_state_t state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (load_i) begin
         state_q <= seed_i;
      end else if (step_i) begin
         state_q <= {^(state_q & TAPS), state_q[LFSR_W-1:1]};
      end
   end

   assign seq_now_o   = state_q[0];
   assign seq_ahead_o = ^(state_q & AHEAD_MASK);

   assert_seed_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> state_q == $past(seed_i))
      else $error("seed not taken on reload");

endmodule

// File: rtl/ul_scr_frame_ctr.sv
module ul_scr_frame_ctr #(
   parameter int unsigned FRAME_LEN = 38400,
   localparam int unsigned CW = $clog2(FRAME_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          adv_i,
   output logic [CW-1:0] count_o,
   output logic          wrap_o,
   output logic          odd_o
);

   localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

   generate
      if (FRAME_LEN < 2 || (FRAME_LEN % 2) != 0) begin : g_bad_len
         $error("ul_scr_frame_ctr: frame length must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load_i) begin
         count_q <= '0;
      end else if (adv_i) begin
         count_q <= (count_q == LAST) ? '0 : count_q + 1'b1;
      end
   end

   assign count_o = count_q;
   assign wrap_o  = adv_i && (count_q == LAST);
   assign odd_o   = count_q[0];

   assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && count_q == LAST) |=> count_q == '0)
      else $error("frame did not wrap at last chip");

   assert_count_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> $stable(count_q))
      else $error("chip counter moved without enable");

endmodule

// File: rtl/ul_long_scrambler.sv
module ul_long_scrambler
   import ul_scr_pkg::*;
#(
   parameter int unsigned IDX_W     = 24,
   parameter int unsigned FRAME_LEN = 38400,
   parameter int unsigned C2_OFFSET = 16777232,
   parameter lfsr_state_t X_TAPS    = X_TAPS_DEF,
   parameter lfsr_state_t Y_TAPS    = Y_TAPS_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] index_i,
   input  logic             chip_en_i,
   output logic             chip_i_o,
   output logic             chip_q_o,
   output logic             frame_start_o,
   output logic [IDX_W-1:0] index_o
);

   localparam int unsigned CW = $clog2(FRAME_LEN);

   generate
      if (IDX_W < 1 || IDX_W > LFSR_W - 1) begin : g_bad_idx
         $error("ul_long_scrambler: index must fit below the top register stage");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             active_q;
   logic             c2_hold_q;
   logic [CW-1:0]    count;
   logic             wrap, odd, adv, reload, step;
   logic             x_now, x_ahead, y_now, y_ahead;
   logic             c1, c2_now, c2_eff;
   lfsr_state_t      x_seed;

   assign adv    = chip_en_i && active_q && !load_i;
   assign reload = load_i || wrap;
   assign step   = adv && !wrap;

   always_comb begin
      x_seed             = '0;
      x_seed[IDX_W-1:0]  = load_i ? index_i : idx_q;
      x_seed[LFSR_W-1]   = 1'b1;
   end

   ul_scr_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_i   (adv),
      .count_o (count),
      .wrap_o  (wrap),
      .odd_o   (odd)
   );

   ul_scr_lfsr #(.TAPS(X_TAPS), .OFFSET(C2_OFFSET)) u_x (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (reload),
      .step_i      (step),
      .seed_i      (x_seed),
      .seq_now_o   (x_now),
      .seq_ahead_o (x_ahead)
   );

   ul_scr_lfsr #(.TAPS(Y_TAPS), .OFFSET(C2_OFFSET)) u_y (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (reload),
      .step_i      (step),
      .seed_i      ('1),
      .seq_now_o   (y_now),
      .seq_ahead_o (y_ahead)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= '0;
         active_q  <= 1'b0;
         c2_hold_q <= 1'b0;
      end else begin
         if (load_i) begin
            idx_q    <= index_i;
            active_q <= 1'b1;
         end
         if (adv && !odd) c2_hold_q <= c2_now;
      end
   end

   assign c1     = x_now ^ y_now;
   assign c2_now = x_ahead ^ y_ahead;
   assign c2_eff = odd ? c2_hold_q : c2_now;

   assign chip_i_o      = active_q & c1;
   assign chip_q_o      = active_q & (c1 ^ odd ^ c2_eff);
   assign frame_start_o = active_q & (count == '0);
   assign index_o       = idx_q;

   assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> frame_start_o && index_o == $past(index_i))
      else $error("load did not restart the frame");

   assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !chip_en_i) |=>
         $stable(chip_i_o) && $stable(chip_q_o) && $stable(frame_start_o))
      else $error("outputs moved while enable low");

   assert_c2_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !odd && !wrap) |=> c2_eff == $past(c2_now))
      else $error("odd chip did not reuse even c2");

endmodule

// File: tb/ul_long_scrambler_bench.sv
module ul_long_scrambler_bench;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME      = 38400;
   localparam int unsigned OFF = 16777232;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [23:0] idx = '0;
   logic        en = 1'b0;
   logic        ci, cq, fs;
   logic [23:0] idx_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ul_long_scrambler u_ul_long_scrambler (
      .clk(clk), .rst_n(rst_n), .load_i(load), .index_i(idx),
      .chip_en_i(en), .chip_i_o(ci), .chip_q_o(cq),
      .frame_start_o(fs), .index_o(idx_o)
   );

   // ---------------- behavioural reference ----------------
   function automatic logic [24:0] step_x(logic [24:0] s);
      return {s[0] ^ s[3], s[24:1]};
   endfunction
   function automatic logic [24:0] step_y(logic [24:0] s);
      return {s[0] ^ s[1] ^ s[2] ^ s[3], s[24:1]};
   endfunction
   function automatic logic [24:0] run_ahead(logic [24:0] s, bit is_x);
      logic [24:0] t;
      t = s;
      for (int unsigned n = 0; n < OFF; n++) t = is_x ? step_x(t) : step_y(t);
      return t;
   endfunction

   logic [24:0] mx0, my0, mx1, my1, x1_seed, y1_seed;
   logic [23:0] m_idx = '0;
   bit          m_act = 0;
   int          m_cnt = 0;
   bit          m_hold = 0;

   initial y1_seed = run_ahead('1, 0);

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_cnt = 0; m_idx = '0;
      end else if (load) begin
         m_idx = idx; m_act = 1; m_cnt = 0;
         mx0 = {1'b1, idx}; my0 = '1;
         x1_seed = run_ahead(mx0, 1);
         mx1 = x1_seed; my1 = y1_seed;
      end else if (en && m_act) begin
         if (m_cnt == FRAME - 1) begin
            m_cnt = 0;
            mx0 = {1'b1, m_idx}; my0 = '1; mx1 = x1_seed; my1 = y1_seed;
         end else begin
            if (m_cnt % 2 == 0) m_hold = mx1[0] ^ my1[0];
            mx0 = step_x(mx0); my0 = step_y(my0);
            mx1 = step_x(mx1); my1 = step_y(my1);
            m_cnt++;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit ei, c2e, eq;
         ei  = m_act && (mx0[0] ^ my0[0]);
         c2e = (m_cnt % 2 == 1) ? m_hold : (mx1[0] ^ my1[0]);
         eq  = m_act && (ei ^ (m_cnt % 2 == 1) ^ c2e);
         chk("R3 I chip", int'(ci), int'(ei));
         chk("R4/R5 Q chip", int'(cq), int'(eq));
         chk("R2/R7 frame_start", int'(fs), int'(m_act && m_cnt == 0));
         chk("R2 index echo", int'(idx_o), int'(m_act ? m_idx : 24'd0));
      end
   end

   // ---------------- stimulus ----------------
   task automatic cycles(int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic do_load(logic [23:0] v, logic e);
      @(negedge clk);
      load = 1'b1; idx = v; en = e;
      @(negedge clk);
      load = 1'b0; en = 1'b1;
      // chip 0 presented now
      chk("R2 frame_start after load", int'(fs), 1);
      chk("R2 index after load", int'(idx_o), int'(v));
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] pat;
      logic       pci, pcq, pfs, pen;
      cycles(4);
      chk("R1 reset chip_i", int'(ci), 0);
      chk("R1 reset frame_start", int'(fs), 0);
      rst_n = 1'b1;
      en = 1'b1;
      cycles(6);
      chk("R1 idle chip_q", int'(cq), 0);
      chk("R1 idle index", int'(idx_o), 0);
      chk("R1 idle frame_start", int'(fs), 0);

      // index 1: x[0]=1, y[0]=1 -> I chip 0
      do_load(24'd1, 1'b1);
      chk("R3 index1 chip0 I", int'(ci), 0);
      cycles(300);

      // irregular enable, stall check
      pat = 8'hA5;
      pci = ci; pcq = cq; pfs = fs; pen = 1'b1;
      for (int k = 0; k < 400; k++) begin
         pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
         en = pat[0];
         pen = en;
         pci = ci; pcq = cq; pfs = fs;
         @(negedge clk);
         if (!pen) begin
            chk("R6 stall I", int'(ci), int'(pci));
            chk("R6 stall Q", int'(cq), int'(pcq));
            chk("R6 stall frame_start", int'(fs), int'(pfs));
         end
      end
      en = 1'b1;

      // mid-frame load, then a full frame
      do_load(24'hABCDEF, 1'b1);
      chk("R8 mid-frame restart index", int'(idx_o), 24'hABCDEF);
      for (int k = 1; k <= FRAME + 40; k++) begin
         @(negedge clk);
         if (k == FRAME - 1) chk("R7 no early frame_start", int'(fs), 0);
         if (k == FRAME) begin
            chk("R7 frame_start at wrap", int'(fs), 1);
            chk("R7 index kept at wrap", int'(idx_o), 24'hABCDEF);
         end
      end

      // load with enable low
      cycles(7);
      do_load(24'hFFFFFF, 1'b0);
      chk("R9 load with enable low", int'(idx_o), 24'hFFFFFF);
      cycles(100);

      // index 0: x[0]=0, y[0]=1 -> I chip 1
      do_load(24'd0, 1'b1);
      chk("R3 index0 chip0 I", int'(ci), 1);
      cycles(200);

      finish_run();
   end

endmodule